// File: doc/BRIEF.md
# VLAN Tag Detector and Field Extractor

This block sits beside the receive datapath and watches the octets of each incoming frame, starting at the first destination-address octet. It decides whether the frame carries an 802.1Q tag by looking at the two octets that follow the two six-octet address fields. If a tag is present and tag detection is switched on, it captures the tag control field and splits it into a priority code, a canonical-format bit and a 12-bit VLAN identifier.

The flag and the three fields are registered outputs. They become valid in the cycle after the last tag-control octet is accepted, and they then stay unchanged until the next frame begins. The receive-status logic downstream can sample them at any point after that, including at the end of the frame. A start-of-frame strobe that comes with the first octet clears all outputs, so a frame with no tag always reports zeros.

Top module: `vlan_tag_extract`

## Requirements
- R1: After reset, `vlan_hit`, `vlan_pri`, `vlan_cfi` and `vlan_vid` are all zero.
- R2: An octet accepted with `rx_sof` high is octet 0 of a new frame. In the next cycle, `vlan_hit` and all three fields read zero.
- R3: A tag is recognised when octet 12 equals 0x81 and octet 13 equals 0x00, with octets counted from 0 at the octet marked by `rx_sof`. On recognition, `vlan_hit` rises in the cycle after octet 15 is accepted, and not before.
- R4: On a recognised tag, `vlan_pri` takes bits 7:5 of octet 14 and `vlan_cfi` takes bit 4 of octet 14. `vlan_vid` is bits 3:0 of octet 14 as its upper nibble, followed by all of octet 15.
- R5: If `cfg_tag_en` is low when octet 15 is accepted, the frame leaves `vlan_hit` and all fields at zero.
- R6: If octet 12 is not 0x81, or octet 13 is not 0x00, the frame leaves `vlan_hit` and all fields at zero.
- R7: A frame that ends before octet 15 is accepted leaves `vlan_hit` and all fields at zero. A frame ends when the next `rx_sof` arrives.
- R8: Once updated, the outputs hold their values through any further octets and idle cycles until the next accepted `rx_sof`.
- R9: Cycles with `rx_vld` low neither advance the octet position nor change any output. This applies whatever `rx_byte` and `rx_sof` are doing in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally in step with the clock |
| cfg_tag_en | input | 1 | Tag detection enable |
| rx_vld | input | 1 | `rx_byte` holds a frame octet this cycle |
| rx_sof | input | 1 | Marks the current octet as octet 0 of a frame (used only when `rx_vld` is high) |
| rx_byte | input | 8 | Frame octet |
| vlan_hit | output | 1 | Frame carries a recognised tag |
| vlan_pri | output | 3 | Priority code from the tag |
| vlan_cfi | output | 1 | Canonical-format bit from the tag |
| vlan_vid | output | 12 | VLAN identifier from the tag |

## Verification
Frames are swept over the four combinations of matching and mismatching type octets, both enable settings, and lengths on both sides of 16 octets. This separates the detection that depends on type and enable from the length cut-off at octet 15. The tag-control octet 14 is then swept through all 256 values, each paired with a distinct octet 15. This shows that every bit lands in the right field with no shift or swap. Alternate frames insert idle cycles that carry the tag type value and a stray start strobe. This tells true octet counting apart from cycle counting. Outputs are checked just before octet 15 and again after trailing octets and idle cycles. These checks pin down the cycle in which the outputs update and show that the values then hold.

// File: rtl/vlan_tag_pkg.sv
package vlan_tag_pkg;
  localparam int OCT_W = 8;
  localparam int PRI_W = 3;
  localparam int VID_W = 12;

  typedef struct packed {
    logic             seen;
    logic [PRI_W-1:0] pri;
    logic             cfi;
    logic [VID_W-1:0] vid;
  } tag_info_t;
endpackage

// File: rtl/vlan_octet_pos.sv
module vlan_octet_pos #(
  parameter int LAST_IDX = 15,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic             rx_sof,
  output logic [CNT_W-1:0] cur_idx
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LAST_IDX + 1);

  logic [CNT_W-1:0] idx_q, idx_d;

  // position of the octet currently on the bus
  always_comb cur_idx = rx_sof ? '0 : idx_q;

  always_comb begin
    idx_d = idx_q;
    if (rx_vld) begin
      if (cur_idx == SAT) idx_d = SAT;
      else                idx_d = cur_idx + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= SAT;
    else        idx_q <= idx_d;
  end

  a_r9_idle_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> $stable(idx_q));
  a_r7_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= SAT);
endmodule

// File: rtl/vlan_type_match.sv
module vlan_type_match
  import vlan_tag_pkg::*;
#(
  parameter int              TAG_POS = 12,
  parameter int              CNT_W   = 5,
  parameter logic [OCT_W-1:0] TYPE_HI = 8'h81,
  parameter logic [OCT_W-1:0] TYPE_LO = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic             rx_sof,
  input  logic [CNT_W-1:0] cur_idx,
  input  logic [OCT_W-1:0] rx_byte,
  output logic             type_ok,
  output logic [OCT_W-1:0] tci_hi
);
  localparam logic [CNT_W-1:0] IDX_HI  = CNT_W'(TAG_POS);
  localparam logic [CNT_W-1:0] IDX_LO  = CNT_W'(TAG_POS + 1);
  localparam logic [CNT_W-1:0] IDX_TCI = CNT_W'(TAG_POS + 2);

  logic             hi_ok_q, hi_ok_d;
  logic             lo_ok_q, lo_ok_d;
  logic [OCT_W-1:0] tci_q, tci_d;
  logic             clr;

  always_comb clr = rx_vld && rx_sof;

  always_comb begin
    hi_ok_d = hi_ok_q;
    lo_ok_d = lo_ok_q;
    tci_d   = tci_q;
    if (clr) begin
      hi_ok_d = 1'b0;
      lo_ok_d = 1'b0;
      tci_d   = '0;
    end else if (rx_vld) begin
      if (cur_idx == IDX_HI)  hi_ok_d = (rx_byte == TYPE_HI);
      if (cur_idx == IDX_LO)  lo_ok_d = (rx_byte == TYPE_LO);
      if (cur_idx == IDX_TCI) tci_d   = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ok_q <= 1'b0;
      lo_ok_q <= 1'b0;
      tci_q   <= '0;
    end else begin
      hi_ok_q <= hi_ok_d;
      lo_ok_q <= lo_ok_d;
      tci_q   <= tci_d;
    end
  end

  always_comb begin
    type_ok = hi_ok_q && lo_ok_q;
    tci_hi  = tci_q;
  end

  a_r6_match_cleared_by_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_sof) |=> !type_ok);
endmodule

// File: rtl/vlan_field_hold.sv
module vlan_field_hold
  import vlan_tag_pkg::*;
#(
  parameter int LAST_IDX = 15,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic             rx_sof,
  input  logic             cfg_tag_en,
  input  logic [CNT_W-1:0] cur_idx,
  input  logic             type_ok,
  input  logic [OCT_W-1:0] tci_hi,
  input  logic [OCT_W-1:0] rx_byte,
  output tag_info_t        info
);
  localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(LAST_IDX);

  tag_info_t info_q, info_d;
  logic      clr, load;

  always_comb begin
    clr  = rx_vld && rx_sof;
    load = rx_vld && !rx_sof && (cur_idx == IDX_LAST) && type_ok && cfg_tag_en;
  end

  always_comb begin
    info_d = info_q;
    if (clr) begin
      info_d = '0;
    end else if (load) begin
      info_d.seen = 1'b1;
      info_d.pri  = tci_hi[OCT_W-1 -: PRI_W];
      info_d.cfi  = tci_hi[OCT_W-1-PRI_W];
      info_d.vid  = {tci_hi[OCT_W-PRI_W-2:0], rx_byte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) info_q <= '0;
    else        info_q <= info_d;
  end

  always_comb info = info_q;

  a_r2_clear_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_sof) |=> (info_q == '0));
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(info_q.seen) |-> $past(cfg_tag_en));
  a_r3_rise_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(info_q.seen) |-> ($past(cur_idx) == IDX_LAST && $past(rx_vld)));
  a_r8_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_vld && (rx_sof || cur_idx == IDX_LAST)) |=> $stable(info_q));
endmodule

// File: rtl/vlan_tag_extract.sv
module vlan_tag_extract
  import vlan_tag_pkg::*;
#(
  parameter int               TAG_POS = 12,
  parameter logic [OCT_W-1:0] TYPE_HI = 8'h81,
  parameter logic [OCT_W-1:0] TYPE_LO = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_tag_en,
  input  logic             rx_vld,
  input  logic             rx_sof,
  input  logic [OCT_W-1:0] rx_byte,
  output logic             vlan_hit,
  output logic [PRI_W-1:0] vlan_pri,
  output logic             vlan_cfi,
  output logic [VID_W-1:0] vlan_vid
);
  localparam int LAST_IDX = TAG_POS + 3;
  localparam int CNT_W    = $clog2(LAST_IDX + 2);

  // asynchronous assert, clocked release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0] cur_idx;
  logic             type_ok;
  logic [OCT_W-1:0] tci_hi;
  tag_info_t        info;

  vlan_octet_pos #(.LAST_IDX(LAST_IDX), .CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_int_n), .rx_vld(rx_vld), .rx_sof(rx_sof), .cur_idx(cur_idx)
  );

  vlan_type_match #(.TAG_POS(TAG_POS), .CNT_W(CNT_W), .TYPE_HI(TYPE_HI), .TYPE_LO(TYPE_LO)) u_match (
    .clk(clk), .rst_n(rst_int_n), .rx_vld(rx_vld), .rx_sof(rx_sof), .cur_idx(cur_idx),
    .rx_byte(rx_byte), .type_ok(type_ok), .tci_hi(tci_hi)
  );

  vlan_field_hold #(.LAST_IDX(LAST_IDX), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .rx_vld(rx_vld), .rx_sof(rx_sof), .cfg_tag_en(cfg_tag_en),
    .cur_idx(cur_idx), .type_ok(type_ok), .tci_hi(tci_hi), .rx_byte(rx_byte), .info(info)
  );

  always_comb begin
    vlan_hit = info.seen;
    vlan_pri = info.pri;
    vlan_cfi = info.cfi;
    vlan_vid = info.vid;
  end

  a_r4_fields_zero_without_hit: assert property (@(posedge clk) disable iff (!rst_int_n)
    !vlan_hit |-> (vlan_pri == '0 && !vlan_cfi && vlan_vid == '0));
endmodule

// File: tb/sim_vlan_tag_extract.sv
module sim_vlan_tag_extract;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_tag_en;
  logic        rx_vld;
  logic        rx_sof;
  logic [7:0]  rx_byte;
  logic        vlan_hit;
  logic [2:0]  vlan_pri;
  logic        vlan_cfi;
  logic [11:0] vlan_vid;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vlan_tag_extract u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tag_en(cfg_tag_en), .rx_vld(rx_vld), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .vlan_hit(vlan_hit), .vlan_pri(vlan_pri), .vlan_cfi(vlan_cfi),
    .vlan_vid(vlan_vid)
  );

  function automatic logic [16:0] outs();
    return {vlan_hit, vlan_pri, vlan_cfi, vlan_vid};
  endfunction

  task automatic chk(input string req, input logic [16:0] exp);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, outs(), exp, $time);
    end
  endtask

  // one frame; octet 0 carries the start strobe
  task automatic send_frame(input int len, input logic [7:0] b12, input logic [7:0] b13,
                            input logic [7:0] b14, input logic [7:0] b15,
                            input logic en, input logic gaps);
    logic [16:0] exp;
    logic [7:0]  d;
    cfg_tag_en = en;
    if (len >= 16 && b12 == 8'h81 && b13 == 8'h00 && en)
      exp = {1'b1, b14[7:5], b14[4], b14[3:0], b15};
    else
      exp = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 1)  chk("R2 cleared after sof", 17'h0);
      if (i == 15) chk("R3 no update before octet 15", 17'h0);
      if (gaps && (i % 3 == 1)) begin
        rx_vld = 1'b0; rx_sof = 1'b1; rx_byte = 8'h81;
        @(negedge clk);
      end
      d = 8'(i * 37 + 5);
      if (i == 12) d = b12;
      if (i == 13) d = b13;
      if (i == 14) d = b14;
      if (i == 15) d = b15;
      rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = d;
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0;
    if (len < 16)         chk("R7 short frame", exp);
    else if (!en)         chk("R5 enable off", exp);
    else if (exp == '0)   chk("R6 type mismatch", exp);
    else                  chk("R3 R4 tag fields", exp);
    repeat (3) @(negedge clk);
    rx_sof = 1'b1; rx_byte = 8'h00;   // stray strobe without valid
    @(negedge clk);
    rx_sof = 1'b0;
    chk("R8 R9 hold after frame", exp);
  endtask

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lens[5] = '{10, 15, 16, 17, 24};
    rst_n = 1'b0; cfg_tag_en = 1'b0; rx_vld = 1'b0; rx_sof = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 17'h0);

    for (int en = 0; en < 2; en++)
      for (int tp = 0; tp < 4; tp++)
        for (int li = 0; li < 5; li++)
          send_frame(lens[li], tp[1] ? 8'h81 : 8'h88, tp[0] ? 8'h00 : 8'h01,
                     8'(8'hA7 + tp * 16 + li), 8'(8'h3C ^ li), en[0], li[0]);

    for (int h = 0; h < 256; h++)
      send_frame(16 + (h % 4), 8'h81, 8'h00, 8'(h), 8'(h) ^ 8'h5A, 1'b1, h[0]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule